// File: doc/BRIEF.md
# Serial Command Port Status Front-End

This block is the receiving end of a chip-select framed serial link. An external host lowers chip select, clocks in a one-byte opcode, and the block acts on it. There are three opcodes. One sets a write-enable latch. One clears that latch. One returns a single status byte that carries the latch. Every other opcode is accepted without effect.

The serial clock, chip select and data input arrive asynchronously. They are resynchronised into the system clock domain, and the edges of the serial clock are found there. The serial clock must therefore run at no more than half the system clock rate. Each frame carries one command. Raising chip select ends the command at any point and returns the block to waiting for a fresh opcode.

The data output comes as a value and an enable. The chip's pad logic turns the pair into a tri-state driver.

Top module: `sfcp_front`

## Requirements
- R1: Data in is sampled on rising serial clock edges while chip select (active low) is asserted, and opcodes are assembled most significant bit first.
- R2: Data out changes only on falling serial clock edges and sends the status byte most significant bit first. Its first bit appears on the falling edge after the eighth opcode bit.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either takes effect only once the eighth opcode bit has been sampled with chip select still asserted.
- R4: Opcode 0x05 returns exactly one status byte. Bit 1 is the write-enable latch and bits 7..2 and 0 read zero. After those eight bits the output is released for the rest of the frame.
- R5: The output enable is high only while chip select is asserted and status bits are being shifted out. It is low during the opcode phase and after chip select rises.
- R6: Raising chip select returns the command state machine to idle. A partially received opcode is discarded and changes nothing.
- R7: Only the first complete byte of a frame is decoded. Later bytes in the same frame are ignored, whether the first opcode was known or unknown.
- R8: Bits arriving on data in while the status byte is being shifted out are ignored.
- R9: After reset the write-enable latch is clear and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the data-out pad driver |

## Verification
The bench uses the default parameters: a two-stage synchroniser, an 8-bit opcode, the latch in status bit 1, and opcodes 0x06, 0x04 and 0x05. With a serial half-period of eight system clocks, the synchroniser delay stays well inside each half-period. This lets the bench sample data out just before each rising edge. It also lets the bench end frames at chosen bit positions, mid-opcode and mid-status. Frames that carry a second byte reach the rule that only the first byte is decoded, and status reads that drive live opcodes on data in reach the rule that input is ignored while status is sent.

// File: rtl/sfcp_pkg.sv
package sfcp_pkg;
   typedef enum logic [1:0] {
      ST_OPCODE = 2'd0,
      ST_STATUS = 2'd1,
      ST_DRAIN  = 2'd2
   } sfcp_state_e;
endpackage

// File: rtl/sfcp_sync.sv
module sfcp_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("sfcp_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) pipe[0] <= RST_VAL;
               else        pipe[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) pipe[g] <= RST_VAL;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfcp_shift_in.sv
module sfcp_shift_in #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         take,
   input  logic         bit_in,
   output logic [W-1:0] word_o,
   output logic         full_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-2:0]  acc;
   logic [CW-1:0] cnt;

   assign word_o = {acc, bit_in};
   assign full_o = take && (cnt == LAST) && !clear;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc <= '0;
         cnt <= '0;
      end else if (take) begin
         acc <= word_o[W-2:0];
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sfcp_shift_out.sv
module sfcp_shift_out #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         rise,
   input  logic         fall,
   output logic         sdo_o,
   output logic         drive_o,
   output logic         busy_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  sreg;
   logic [CW-1:0] cnt;
   logic          run;
   logic          primed;

   assign sdo_o   = sreg[W-1];
   assign drive_o = run && primed;
   assign busy_o  = run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg   <= '0;
         cnt    <= '0;
         run    <= 1'b0;
         primed <= 1'b0;
      end else if (clear) begin
         run    <= 1'b0;
         primed <= 1'b0;
      end else if (load) begin
         sreg   <= load_val;
         cnt    <= '0;
         run    <= 1'b1;
         primed <= 1'b0;
      end else begin
         if (fall && run) begin
            if (!primed) primed <= 1'b1;
            else         sreg   <= {sreg[W-2:0], 1'b0};
         end
         if (rise && run && primed) begin
            if (cnt == LAST) run <= 1'b0;
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sfcp_front.sv
module sfcp_front #(
   parameter int               SYNC_STAGES = 2,
   parameter int               BYTE_W      = 8,
   parameter int               WEL_BIT     = 1,
   parameter logic [BYTE_W-1:0] OP_SET_WE  = 8'h06,
   parameter logic [BYTE_W-1:0] OP_CLR_WE  = 8'h04,
   parameter logic [BYTE_W-1:0] OP_STATUS  = 8'h05
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   import sfcp_pkg::*;

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("sfcp_front: BYTE_W must be at least 2");
      end
      if (WEL_BIT < 0 || WEL_BIT >= BYTE_W) begin : g_bad_bit
         $error("sfcp_front: WEL_BIT out of range");
      end
      if (OP_SET_WE == OP_CLR_WE || OP_SET_WE == OP_STATUS || OP_CLR_WE == OP_STATUS) begin : g_bad_op
         $error("sfcp_front: opcodes must be distinct");
      end
   endgenerate

   // sync vector: [2]=sck, [1]=cs_n, [0]=sdi
   logic [2:0] in_s;
   sfcp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({sck, cs_n, sdi}),
      .q       (in_s)
   );

   logic sck_prev;
   logic cs_act, sck_rise, sck_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= in_s[2];
   end

   assign cs_act   = !in_s[1];
   assign sck_rise = cs_act && in_s[2] && !sck_prev;
   assign sck_fall = cs_act && !in_s[2] && sck_prev;

   sfcp_state_e        state;
   logic               wel;
   logic               take, byte_full, load;
   logic [BYTE_W-1:0]  word, status;
   logic               tx_busy;

   assign take = sck_rise && (state == ST_OPCODE);

   sfcp_shift_in #(.W(BYTE_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!cs_act),
      .take   (take),
      .bit_in (in_s[0]),
      .word_o (word),
      .full_o (byte_full)
   );

   always_comb begin
      status          = '0;
      status[WEL_BIT] = wel;
   end

   assign load = byte_full && (word == OP_STATUS);

   sfcp_shift_out #(.W(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!cs_act),
      .load     (load),
      .load_val (status),
      .rise     (sck_rise),
      .fall     (sck_fall),
      .sdo_o    (sdo),
      .drive_o  (sdo_oe),
      .busy_o   (tx_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_OPCODE;
         wel   <= 1'b0;
      end else if (!cs_act) begin
         state <= ST_OPCODE;
      end else begin
         unique case (state)
            ST_OPCODE: if (byte_full) begin
               if (word == OP_SET_WE)      wel <= 1'b1;
               else if (word == OP_CLR_WE) wel <= 1'b0;
               state <= (word == OP_STATUS) ? ST_STATUS : ST_DRAIN;
            end
            ST_STATUS: if (!tx_busy) state <= ST_DRAIN;
            default:   state <= ST_DRAIN;
         endcase
      end
   end
endmodule

// File: rtl/sfcp_front_chk.sv
module sfcp_front_chk (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cs_act,
   input logic                   sck_fall,
   input logic                   sdo,
   input logic                   sdo_oe,
   input logic                   wel,
   input logic                   byte_full,
   input sfcp_pkg::sfcp_state_e  state
);
   import sfcp_pkg::*;

   a_r5_release_drops_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo_oe);

   a_r2_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && !sck_fall) |=> $stable(sdo));

   a_r3_wel_needs_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_full |=> $stable(wel));

   a_r6_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (state == ST_OPCODE));

   a_r8_no_decode_outside_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_OPCODE) |-> !byte_full);
endmodule

bind sfcp_front sfcp_front_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .sck_fall  (sck_fall),
   .sdo       (sdo),
   .sdo_oe    (sdo_oe),
   .wel       (wel),
   .byte_full (byte_full),
   .state     (state)
);

// File: tb/sfcp_front_tb.sv
module sfcp_front_tb;
   localparam int HALF = 8;
   localparam int NV   = 6;
   localparam logic [7:0] OPS [NV] = '{8'h06, 8'h04, 8'h06, 8'h06, 8'hA5, 8'h04};
   localparam logic       EXP [NV] = '{1'b1,  1'b0,  1'b1,  1'b1,  1'b1,  1'b0};

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic sdo, sdo_oe;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sfcp_front u_dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                     .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic r, output logic oe);
      sdi = b;
      wait_clk(HALF);
      r  = sdo;
      oe = sdo_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   task automatic xfer_byte(input logic [7:0] din, output logic [7:0] dout,
                            output logic all_oe, output logic any_oe);
      logic r, oe;
      all_oe = 1'b1;
      any_oe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(din[i], r, oe);
         dout[i] = r;
         all_oe  = all_oe & oe;
         any_oe  = any_oe | oe;
      end
   endtask

   task automatic frame_start();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic frame_end();
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic cmd_frame(input logic [7:0] op);
      logic [7:0] d;
      logic a, y;
      frame_start();
      xfer_byte(op, d, a, y);
      frame_end();
   endtask

   task automatic read_status(input logic [7:0] din, output logic [7:0] st, output logic all_oe);
      logic [7:0] d;
      logic a, y;
      frame_start();
      xfer_byte(8'h05, d, a, y);
      chk(!y, "R5 opcode phase oe", y, 0);
      xfer_byte(din, st, all_oe, y);
      frame_end();
   endtask

   initial begin
      logic [7:0] st, d;
      logic a, y, r, oe;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R9 reset state
      chk(sdo_oe == 1'b0, "R9 oe after reset", sdo_oe, 0);
      read_status(8'h00, st, a);
      chk(st == 8'h00, "R9 wel clear after reset", st, 0);
      chk(a == 1'b1, "R4 oe through status byte", a, 1);

      // R1 R3 R4 R7 vector walk
      for (int i = 0; i < NV; i++) begin
         cmd_frame(OPS[i]);
         read_status(8'h00, st, a);
         chk(st == {6'b0, EXP[i], 1'b0}, "R3 status after opcode", st, {6'b0, EXP[i], 1'b0});
         chk(a == 1'b1, "R2 status bits driven", a, 1);
      end

      // R6 partial opcode discarded: seven bits of 0x06 then release
      frame_start();
      for (int i = 7; i >= 1; i--) bit_xfer(((8'h06 >> i) & 8'h01) != 0, r, oe);
      frame_end();
      chk(sdo_oe == 1'b0, "R5 oe low with cs released", sdo_oe, 0);
      read_status(8'h00, st, a);
      chk(st == 8'h00, "R6 partial byte no effect", st, 0);

      // R7 unknown opcode then set in same frame ignored
      frame_start();
      xfer_byte(8'hFF, d, a, y);
      xfer_byte(8'h06, d, a, y);
      chk(!y, "R7 no output for unknown", y, 0);
      frame_end();
      read_status(8'h00, st, a);
      chk(st == 8'h00, "R7 second byte ignored after unknown", st, 0);

      // R7 set then clear in same frame: clear ignored
      frame_start();
      xfer_byte(8'h06, d, a, y);
      xfer_byte(8'h04, d, a, y);
      frame_end();
      read_status(8'h00, st, a);
      chk(st == 8'h02, "R7 second byte ignored after set", st, 8'h02);

      // R8 clear opcode on sdi during status ignored; R4 one byte only
      frame_start();
      xfer_byte(8'h05, d, a, y);
      xfer_byte(8'h04, st, a, y);
      chk(st == 8'h02, "R8 status while sdi busy", st, 8'h02);
      xfer_byte(8'h04, d, a, y);
      chk(!y, "R4 output released after one byte", y, 0);
      frame_end();
      read_status(8'h00, st, a);
      chk(st == 8'h02, "R8 wel kept after status read", st, 8'h02);

      // R6 release mid-status, then new frame decodes clear
      frame_start();
      xfer_byte(8'h05, d, a, y);
      bit_xfer(1'b0, r, oe);
      bit_xfer(1'b0, r, oe);
      chk(oe == 1'b1, "R5 oe while shifting", oe, 1);
      bit_xfer(1'b0, r, oe);
      frame_end();
      chk(sdo_oe == 1'b0, "R6 oe drops on mid-status release", sdo_oe, 0);
      cmd_frame(8'h04);
      read_status(8'h00, st, a);
      chk(st == 8'h00, "R6 fresh opcode after abort", st, 0);

      // R1 MSB first: 0x60 (bit-reversed 0x06) must not set
      cmd_frame(8'h60);
      read_status(8'h00, st, a);
      chk(st == 8'h00, "R1 msb-first decode", st, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule